// File: doc/BRIEF.md
# Clock Lane Enable Register Slave over I2C

This block is an I2C target that keeps three 8-bit configuration registers whose bits switch individual output clock lanes on or off. It is meant to sit beside a fanout clock buffer: 18 lane enables leave the block as a registered vector, and the buffer holds a lane low when its enable is 0. SCL and SDA are oversampled in the system clock domain, and SDA is driven only by pulling it low.

Writes always use the same block form. After the address byte the master sends two header bytes. The slave acknowledges them and throws their contents away. The data bytes that follow fill the registers from the lowest upward. Reads have no pointer: they always return the registers from the lowest one. A power-down input makes the slave leave the bus alone without losing what has been programmed.

Top module: `i2c_lane_cfg`

## Requirements
- R1: After reset every register bit is 1, so `lane_en_o` is 0x3FFFF, SDA is released, and a read returns 0xFF for every byte.
- R2: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), meaning 7-bit address 0x69 followed by the direction bit, with 1 meaning read. Any other address gets no acknowledge, and the slave ignores the rest of that transfer.
- R3: On a write, the first two bytes after the address are acknowledged and change no register, whatever their values.
- R4: Write data bytes load register 0, then register 1, then register 2. A STOP after any whole byte leaves the later registers unchanged.
- R5: Lanes 7..0 follow register 0 bits 7..0. Lanes 15..8 follow register 1 bits 7..0. Lane 17 follows register 2 bit 7 and lane 16 follows register 2 bit 6. Register 2 bits 5..0 drive no lane but are stored and read back.
- R6: Write data bytes after the third are acknowledged and discarded.
- R7: A read returns register 0, 1, 2 in that order, most significant bit first, with no count byte. Any byte past register 2 reads 0xFF.
- R8: If the master does not acknowledge a read byte, the slave stops sending and keeps SDA released until the next START.
- R9: A repeated START ends the current transfer and begins address matching again. Data bytes already completed stay in their registers.
- R10: While `pwr_down_i` is 1, the slave releases SDA within one clock, acknowledges nothing and writes nothing, and all register contents are retained.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP in the middle of a byte discards that partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| pwr_down_i | input | 1 | Power-down; 1 makes the slave release and ignore the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| lane_en_o | output | 18 | Registered clock lane enables, 1 = lane running |

## Verification
Each bus line passes through a two-flop synchronizer and a three-sample filter, so a bus edge takes effect about six system cycles after it happens. The slave's SDA drive then follows one cycle later. The bench spaces its bus phases twelve cycles apart and samples SDA, for acknowledges and read data, one phase after it raises SCL, long after the slave has settled. A register write commits at the SCL fall that ends a byte and reaches `lane_en_o` two cycles later, so the lanes are checked one phase after STOP. The power-down release is due one cycle after the input rises, and the bench looks at `sda_pull_o` two falling clock edges later.

// File: rtl/i2c_lane_pkg.sv
package i2c_lane_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  // Idle bus level is high; the filtered level moves only on a unanimous history.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        line_o <= 1'b1;
      else if (~|hist_q)
        line_o <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int LINES = 2;
  localparam int SCL_IDX = 1;
  localparam int SDA_IDX = 0;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] filt_lines;
  logic             scl_q, sda_q;
  logic             scl_f, sda_f;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[SCL_IDX];
  assign sda_f = filt_lines[SDA_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign sda_o      = sda_f;
  assign scl_rise_o = scl_f & ~scl_q;
  assign scl_fall_o = ~scl_f & scl_q;
  // SDA edges qualified by SCL high both before and after the edge (R11)
  assign start_o    = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_o     = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import i2c_lane_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_REGS  = 3,
  parameter int         PTR_W     = 2,
  parameter int         HDR_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_pull_o
);

  localparam int                HW      = $clog2(HDR_BYTES + 1);
  localparam logic [HW-1:0]     HDR_END = HW'(HDR_BYTES);
  localparam logic [PTR_W-1:0]  PTR_END = PTR_W'(NUM_REGS);
  localparam logic [3:0]        BIT_ALL = 4'(BYTE_W);
  localparam logic [3:0]        BIT_LST = 4'(BYTE_W - 1);

  bus_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              rw_q;
  logic              is_addr_q;
  logic [HW-1:0]     hdr_q;
  logic [PTR_W-1:0]  ptr_q;

  assign rd_addr_o = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '1;
      rw_q       <= 1'b0;
      is_addr_q  <= 1'b0;
      hdr_q      <= '0;
      ptr_q      <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      wr_en_o    <= 1'b0;
      sda_pull_o <= !pwr_down_i &&
                    ((state_q == ST_ACK) || (state_q == ST_TX && !shift_q[BYTE_W-1]));
      if (pwr_down_i) begin
        state_q <= ST_IDLE;
      end else if (start_i) begin
        state_q   <= ST_RX;
        cnt_q     <= '0;
        is_addr_q <= 1'b1;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != BIT_ALL) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == BIT_ALL) begin
              if (is_addr_q) begin
                if (shift_q[BYTE_W-1:1] == DEV_ADDR) begin
                  state_q <= ST_ACK;
                  rw_q    <= shift_q[0];
                  ptr_q   <= '0;
                  hdr_q   <= '0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q <= ST_ACK;
                if (hdr_q != HDR_END) begin
                  hdr_q <= hdr_q + HW'(1);
                end else if (ptr_q != PTR_END) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_q;
                  wr_data_o <= shift_q;
                  ptr_q     <= ptr_q + PTR_W'(1);
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt_q     <= '0;
              is_addr_q <= 1'b0;
              if (rw_q) begin
                state_q <= ST_TX;
                shift_q <= rd_data_i;
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == BIT_LST) begin
                state_q <= ST_MACK;
              end else begin
                shift_q <= {shift_q[BYTE_W-2:0], 1'b1};
                cnt_q   <= cnt_q + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              if (sda_i)
                state_q <= ST_IDLE;
              else if (ptr_q != PTR_END)
                ptr_q <= ptr_q + PTR_W'(1);
            end else if (scl_fall_i) begin
              state_q <= ST_TX;
              cnt_q   <= '0;
              shift_q <= rd_data_i;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: any START outside power-down begins a fresh address byte
  assert_start_enters_rx_R9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !pwr_down_i) |=> (state_q == ST_RX));

  // R11: STOP returns the slave to idle
  assert_stop_goes_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i && !pwr_down_i) |=> (state_q == ST_IDLE));

  // R10: SDA released one clock after power-down
  assert_pd_release_R10: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i |=> !sda_pull_o);

  // R10: no register write issued from a power-down cycle
  assert_pd_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i |=> !wr_en_o);

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
  import i2c_lane_pkg::*;
#(
  parameter int LANES    = 18,
  parameter int NUM_REGS = 3,
  parameter int PTR_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [LANES-1:0]  lane_en_o
);

  localparam int               FULL_REGS = LANES / BYTE_W;
  localparam int               TAIL      = LANES % BYTE_W;
  localparam logic [PTR_W-1:0] PTR_END   = PTR_W'(NUM_REGS);

  logic [BYTE_W-1:0] mem_q [NUM_REGS];
  logic [LANES-1:0]  lane_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++)
        mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_addr_i < PTR_END) ? mem_q[rd_addr_i] : '1;

  // Full bytes map bit-for-bit; a partial last byte uses its top bits (R5)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int SRC_BYTE = l / BYTE_W;
    localparam int SRC_BIT  = (l < FULL_REGS * BYTE_W) ? (l % BYTE_W)
                                                       : (BYTE_W - TAIL) + (l - FULL_REGS * BYTE_W);
    assign lane_d[l] = mem_q[SRC_BYTE][SRC_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst)
      lane_en_o <= '1;
    else
      lane_en_o <= lane_d;
  end

  // R6: writes never land beyond the last register
  assert_wr_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> (wr_addr_i < PTR_END));

  // R1: every lane enabled right after reset
  assert_lanes_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lane_en_o == '1));

endmodule

// File: rtl/i2c_lane_cfg.sv
module i2c_lane_cfg
  import i2c_lane_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         LANES       = 18,
  parameter int         HDR_BYTES   = 2,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             pwr_down_i,
  output logic             sda_pull_o,
  output logic [LANES-1:0] lane_en_o
);

  localparam int NUM_REGS = (LANES + BYTE_W - 1) / BYTE_W;
  localparam int PTR_W    = $clog2(NUM_REGS + 1);

  logic              sda_f, scl_rise, scl_fall, start_p, stop_p;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_bus_events #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_p),
    .stop_o    (stop_p)
  );

  i2c_cfg_engine #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W),
    .HDR_BYTES(HDR_BYTES)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .pwr_down_i(pwr_down_i),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_p),
    .stop_i    (stop_p),
    .sda_i     (sda_f),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sda_pull_o(sda_pull_o)
  );

  i2c_cfg_regs #(
    .LANES   (LANES),
    .NUM_REGS(NUM_REGS),
    .PTR_W   (PTR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .lane_en_o(lane_en_o)
  );

endmodule

// File: tb/sim_i2c_lane_cfg.sv
module sim_i2c_lane_cfg;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 12;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        pwr_down = 1'b0;
  logic        sda_pull;
  logic        sda_bus;
  logic [17:0] lanes;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [7:0]  model [3];
  logic [7:0]  wbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_lane_cfg u0 (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .pwr_down_i(pwr_down),
    .sda_pull_o(sda_pull),
    .lane_en_o (lanes)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [17:0] exp_lanes();
    return {model[2][7:6], model[1], model[0]};
  endfunction

  task automatic tick();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(); m_scl = 1'b1; tick(); m_sda = 1'b0; tick(); m_scl = 1'b0; tick();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(); m_scl = 1'b1; tick(); m_sda = 1'b1; tick();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      m_sda = b[i]; tick(); m_scl = 1'b1; tick(); tick(); m_scl = 1'b0; tick();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    m_sda = 1'b1; tick(); m_scl = 1'b1; tick();
    acked = (sda_bus == 1'b0);
    tick(); m_scl = 1'b0; tick();
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(); m_scl = 1'b1; tick();
      b[i] = sda_bus;
      tick(); m_scl = 1'b0; tick();
    end
    m_sda = ~master_ack; tick(); m_scl = 1'b1; tick(); tick(); m_scl = 1'b0; tick();
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] addr, input int n, input string req);
    logic ack;
    logic hit;
    hit = (addr == 8'hD2) && !pwr_down;
    bus_start();
    send_byte(addr, ack);
    check({req, " R2 address ack"}, ack, hit);
    for (int h = 0; h < 2; h++) begin
      send_byte(8'($urandom), ack);
      check({req, " R3 header ack"}, ack, hit);
    end
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check({req, " R6 data ack"}, ack, hit);
      if (hit && i < 3) model[i] = wbuf[i];
    end
    bus_stop();
    tick();
    check({req, " R4 R5 lanes"}, 32'(lanes), 32'(exp_lanes()));
  endtask

  task automatic do_read(input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, ack);
    check({req, " R2 read address ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      check({req, " R7 read byte"}, b, (i < 3) ? model[i] : 8'hFF);
    end
    bus_stop();
    tick();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    void'($urandom(32'd1729));
    for (int i = 0; i < 3; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 lanes after reset", 32'(lanes), 32'h3FFFF);
    check("R1 SDA released", sda_pull, 1'b0);
    do_read(4, "R1 reset readback");

    // R5: distinct patterns per register
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h40;
    do_write(8'hD2, 3, "R5 map");
    check("R5 lane16 only", 32'(lanes), 32'h13CA5);
    do_read(4, "R7 readback");

    // R4: single data byte
    wbuf[0] = 8'h0F;
    do_write(8'hD2, 1, "R4 partial");
    // R3: headers only
    do_write(8'hD2, 0, "R3 headers only");
    // R6: overflow bytes
    wbuf[0] = 8'h81; wbuf[1] = 8'h7E; wbuf[2] = 8'h80; wbuf[3] = 8'h00; wbuf[4] = 8'h55;
    do_write(8'hD2, 5, "R6 overflow");
    check("R6 lanes after overflow", 32'(lanes), 32'h27E81);

    // R2: foreign addresses
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
    do_write(8'hA4, 3, "R2 foreign");
    do_write(8'h52, 3, "R2 msb flip");

    // R8: NACK ends the read
    bus_start();
    send_byte(8'hD3, ack);
    check("R8 address ack", ack, 1'b1);
    recv_byte(1'b0, b);
    check("R8 first byte", b, model[0]);
    recv_byte(1'b0, b);
    check("R8 released after NACK", b, 8'hFF);
    check("R8 no pull", sda_pull, 1'b0);
    bus_stop();
    tick();

    // R9: repeated START keeps completed byte
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h11, ack);
    check("R9 data ack", ack, 1'b1);
    model[0] = 8'h11;
    send_bits(8'h22, 4);
    bus_start();
    send_byte(8'hD3, ack);
    check("R9 address ack after restart", ack, 1'b1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i < 2, b);
      check("R9 readback after restart", b, model[i]);
    end
    bus_stop();
    tick();

    // R11: STOP mid-byte discards the partial byte
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h33, ack);
    model[0] = 8'h33;
    send_bits(8'h44, 5);
    bus_stop();
    tick();
    check("R11 partial byte dropped", 32'(lanes), 32'(exp_lanes()));

    // R10: power-down during an acknowledge
    bus_start();
    send_bits(8'hD2, 8);
    m_sda = 1'b1; tick(); m_scl = 1'b1; tick();
    check("R2 ack before power-down", sda_bus, 1'b0);
    pwr_down = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 release on power-down", sda_pull, 1'b0);
    tick(); m_scl = 1'b0; tick();
    bus_stop();
    tick();
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
    do_write(8'hD2, 3, "R10 ignored write");
    pwr_down = 1'b0;
    tick();
    do_read(3, "R10 retained");

    // Random traffic
    for (int it = 0; it < 18; it++) begin
      int n;
      n = $urandom_range(0, 5);
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
      do_write(8'hD2, n, "R4 random");
      if (it % 3 == 0) do_read($urandom_range(1, 4), "R7 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule